// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block monitors eight external interrupt request pins, numbered 7 down to 0, and turns clean events on them into sticky per-pin flags plus a single wake-up request for the power sequencer. Every pin passes through a two-flop synchronizer and then a per-pin glitch filter. The filter runs on the master clock and changes its filtered level only after the synchronized pin has held a new value for a fixed run of consecutive cycles. That run is 10 master cycles normally and 22 master cycles while the chip is in HALT.

Each pin has its own trigger selection: rising edge, falling edge, high level or low level. A qualified event always sets the pin's detect flag. It also sets the pin's request flag when the current power mode allows that trigger type. RUN and SLEEP accept all four types. HALT and STOP accept only the two level types. The wake-up output is high whenever any request flag is set and the chip is not in RUN. It is a combinational function of the flags, so the power sequencer can use it without a running clock. Software clears flags with per-bit clear strobes. A new event in the same cycle as a clear wins, and the flag stays set.

Each per-pin filter is a two-state machine. FLT_STEADY means the synchronized pin equals the filtered level. It goes to FLT_COUNT on the first cycle the two differ. FLT_COUNT returns to FLT_STEADY in either of two cases: the pin goes back before the window ends, which discards the count, or the count reaches the window, which flips the filtered level.

Top module: `ext_irq_detector`

## Requirements
- R1: After reset, all request flags, all detect flags and `wake_req` are 0.
- R2: Outside HALT (RUN, SLEEP and STOP), a pin change is qualified only if the pin is sampled at its new value on 10 consecutive master clock edges. A change held for 9 edges produces no event.
- R3: In HALT (`pwr_mode`=2), the qualification window is 22 consecutive master clock edges. A change held for 21 edges produces no event.
- R4: Trigger codes in `trig_cfg[2i+1:2i]` are 0 = rising edge, 1 = falling edge, 2 = high level and 3 = low level. An edge trigger responds only to its own direction. A level trigger responds while the filtered pin is at its active level.
- R5: A qualified event sets the pin's `det_flag` bit in every power mode.
- R6: Power modes are encoded on `pwr_mode` as 0 = RUN, 1 = SLEEP, 2 = HALT and 3 = STOP. In HALT and STOP, an event on an edge-triggered pin does not set its `req_flag` bit and does not raise `wake_req`.
- R7: In SLEEP, each of the four trigger types sets `req_flag` and so raises `wake_req`.
- R8: `wake_req` is 1 exactly when any `req_flag` bit is set and `pwr_mode` is not RUN. It follows these inputs combinationally.
- R9: Flags stay set until software clears them. A 1 in bit i of `clr_req` or `clr_det` for one cycle clears only that pin's flag of that kind.
- R10: When a clear and a new event for the same flag happen in the same cycle, the flag remains set.
- R11: Pins are independent. An event on one pin changes no flag of any other pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 8 | Raw external interrupt pins, asynchronous |
| trig_cfg | input | 16 | Two-bit trigger code per pin, pin i in bits [2i+1:2i] |
| pwr_mode | input | 2 | Current power mode: 0 RUN, 1 SLEEP, 2 HALT, 3 STOP |
| clr_req | input | 8 | Per-pin clear strobe for request flags |
| clr_det | input | 8 | Per-pin clear strobe for detect flags |
| req_flag | output | 8 | Sticky request flags |
| det_flag | output | 8 | Sticky detect flags |
| wake_req | output | 1 | Wake-up request to the power sequencer |

## Verification
The hardest behaviour to reach from the ports is the exact edge of each qualification window: one cycle short must be rejected and the exact length must be accepted. This matters in particular for the longer HALT window. The stimulus changes the pin just after a falling clock edge and holds it for a counted number of rising edges, so the filter sees exactly N samples; the bench then checks the flags once the pipeline has settled. The same-cycle race between a clear strobe and a new event is produced by holding a level-triggered pin at its active level, which re-qualifies it on every cycle, while the clear strobe is pulsed.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic [1:0] {
        TRG_RISE = 2'd0,
        TRG_FALL = 2'd1,
        TRG_HIGH = 2'd2,
        TRG_LOW  = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_SLEEP = 2'd1,
        PM_HALT  = 2'd2,
        PM_STOP  = 2'd3
    } pwr_e;

    typedef enum logic {
        FLT_STEADY = 1'b0,
        FLT_COUNT  = 1'b1
    } flt_state_e;

endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/eid_filter.sv
module eid_filter
    import ext_irq_pkg::*;
#(
    parameter int NORM_CYC = 10,
    parameter int HALT_CYC = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic long_win,
    output logic lvl_next,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int MAX_CYC = (HALT_CYC > NORM_CYC) ? HALT_CYC : NORM_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             filt_q, filt_d;
    logic [CNT_W-1:0] limit;

    assign limit = long_win ? CNT_W'(HALT_CYC - 1) : CNT_W'(NORM_CYC - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_STEADY;
            cnt_q   <= '0;
            filt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            filt_q  <= filt_d;
        end
    end

    // next state and filtered level
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        filt_d  = filt_q;
        unique case (state_q)
            FLT_STEADY: begin
                if (sync_in != filt_q) begin
                    state_d = FLT_COUNT;
                    cnt_d   = CNT_W'(1);
                end
            end
            FLT_COUNT: begin
                if (sync_in == filt_q) begin
                    state_d = FLT_STEADY;
                    cnt_d   = '0;
                end else if (cnt_q >= limit) begin
                    state_d = FLT_STEADY;
                    cnt_d   = '0;
                    filt_d  = sync_in;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d = FLT_STEADY;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        lvl_next = filt_d;
        rise_evt = filt_d & ~filt_q;
        fall_evt = ~filt_d & filt_q;
    end
endmodule

// File: rtl/eid_flags.sv
module eid_flags #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] evt,
    input  logic [NPINS-1:0] permit,
    input  logic [NPINS-1:0] clr_req,
    input  logic [NPINS-1:0] clr_det,
    output logic [NPINS-1:0] req_q,
    output logic [NPINS-1:0] det_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            det_q <= '0;
        end else begin
            req_q <= (req_q & ~clr_req) | (evt & permit);
            det_q <= (det_q & ~clr_det) | evt;
        end
    end
endmodule

// File: rtl/ext_irq_detector.sv
module ext_irq_detector
    import ext_irq_pkg::*;
#(
    parameter int NPINS    = 8,
    parameter int NORM_CYC = 10,
    parameter int HALT_CYC = 22
) (
    input  logic [0:0]         clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   pin_in,
    input  logic [2*NPINS-1:0] trig_cfg,
    input  logic [1:0]         pwr_mode,
    input  logic [NPINS-1:0]   clr_req,
    input  logic [NPINS-1:0]   clr_det,
    output logic [NPINS-1:0]   req_flag,
    output logic [NPINS-1:0]   det_flag,
    output logic               wake_req
);
    pwr_e             mode;
    logic             in_halt;
    logic             edge_ok;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] evt;
    logic [NPINS-1:0] permit;

    assign mode    = pwr_e'(pwr_mode);
    assign in_halt = (mode == PM_HALT);
    assign edge_ok = (mode == PM_RUN) || (mode == PM_SLEEP);

    eid_sync #(.WIDTH(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic  lvl, rise, fall;
        trig_e trg;

        assign trg = trig_e'(trig_cfg[2*i +: 2]);

        eid_filter #(.NORM_CYC(NORM_CYC), .HALT_CYC(HALT_CYC)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_in  (pin_sync[i]),
            .long_win (in_halt),
            .lvl_next (lvl),
            .rise_evt (rise),
            .fall_evt (fall)
        );

        always_comb begin
            unique case (trg)
                TRG_RISE: begin evt[i] = rise; permit[i] = edge_ok; end
                TRG_FALL: begin evt[i] = fall; permit[i] = edge_ok; end
                TRG_HIGH: begin evt[i] = lvl;  permit[i] = 1'b1;    end
                TRG_LOW:  begin evt[i] = ~lvl; permit[i] = 1'b1;    end
                default:  begin evt[i] = 1'b0; permit[i] = 1'b0;    end
            endcase
        end
    end

    eid_flags #(.NPINS(NPINS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .permit  (permit),
        .clr_req (clr_req),
        .clr_det (clr_det),
        .req_q   (req_flag),
        .det_q   (det_flag)
    );

    assign wake_req = (|req_flag) && (mode != PM_RUN);
endmodule

// File: rtl/eid_checker.sv
module eid_checker #(
    parameter int NPINS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2*NPINS-1:0] trig_cfg,
    input logic [1:0]         pwr_mode,
    input logic [NPINS-1:0]   clr_req,
    input logic [NPINS-1:0]   clr_det,
    input logic [NPINS-1:0]   req_flag,
    input logic [NPINS-1:0]   det_flag,
    input logic               wake_req
);
    // R8
    wake_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ((|req_flag) && (pwr_mode != 2'd0)));

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        // R6
        deep_mode_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(req_flag[i]) && ($past(pwr_mode) >= 2'd2)) |-> $past(trig_cfg[2*i+1]));

        // R5
        req_with_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(req_flag[i]) && !$past(clr_det[i])) |-> det_flag[i]);

        // R9
        req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(req_flag[i]) |-> $past(clr_req[i]));

        // R9
        det_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(det_flag[i]) |-> $past(clr_det[i]));
    end
endmodule

bind ext_irq_detector eid_checker #(.NPINS(NPINS)) u_eid_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_cfg (trig_cfg),
    .pwr_mode (pwr_mode),
    .clr_req  (clr_req),
    .clr_det  (clr_det),
    .req_flag (req_flag),
    .det_flag (det_flag),
    .wake_req (wake_req)
);

// File: tb/ext_irq_detector_test.sv
module ext_irq_detector_test;
    logic        clk;
    logic        rst_n;
    logic [7:0]  pin_in;
    logic [15:0] trig_cfg;
    logic [1:0]  pwr_mode;
    logic [7:0]  clr_req;
    logic [7:0]  clr_det;
    logic [7:0]  req_flag;
    logic [7:0]  det_flag;
    logic        wake_req;

    int n_chk;
    int n_bad;

    ext_irq_detector uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .trig_cfg (trig_cfg),
        .pwr_mode (pwr_mode),
        .clr_req  (clr_req),
        .clr_det  (clr_det),
        .req_flag (req_flag),
        .det_flag (det_flag),
        .wake_req (wake_req)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_trig(input int pin, input logic [1:0] code);
        trig_cfg[2*pin +: 2] = code;
    endtask

    task automatic pulse(input int pin, input int len);
        @(negedge clk);
        pin_in[pin] = 1'b1;
        repeat (len) @(negedge clk);
        pin_in[pin] = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_req = 8'hFF;
        clr_det = 8'hFF;
        @(negedge clk);
        clr_req = 8'h00;
        clr_det = 8'h00;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 req after reset", req_flag, 8'h00);
        chk("R1 det after reset", det_flag, 8'h00);
        chk("R1 wake after reset", wake_req, 1'b0);
    endtask

    task automatic t_norm_window();
        pwr_mode = 2'd0;
        pulse(0, 9);
        chk("R2 9-cycle pulse rejected", det_flag, 8'h00);
        pulse(0, 10);
        chk("R2 10-cycle pulse det", det_flag, 8'h01);
        chk("R5 run req", req_flag, 8'h01);
        chk("R8 no wake in run", wake_req, 1'b0);
        @(negedge clk); clr_req = 8'h01;
        @(negedge clk); clr_req = 8'h00;
        @(negedge clk);
        chk("R9 req cleared only", req_flag, 8'h00);
        chk("R9 det untouched", det_flag, 8'h01);
        clear_all();
    endtask

    task automatic t_falling();
        set_trig(1, 2'd1);
        @(negedge clk); pin_in[1] = 1'b1;
        repeat (20) @(negedge clk);
        chk("R4 fall ignores rise", det_flag, 8'h00);
        pin_in[1] = 1'b0;
        repeat (20) @(negedge clk);
        chk("R4 fall detected", det_flag, 8'h02);
        clear_all();
    endtask

    task automatic t_halt_window();
        pwr_mode = 2'd2;
        set_trig(2, 2'd2);
        pulse(2, 21);
        chk("R3 21-cycle halt rejected", req_flag, 8'h00);
        pulse(2, 22);
        chk("R3 22-cycle halt req", req_flag, 8'h04);
        chk("R8 wake in halt", wake_req, 1'b1);
        clear_all();
        chk("R8 wake drops on clear", wake_req, 1'b0);
    endtask

    task automatic t_halt_edge();
        pwr_mode = 2'd2;
        pulse(3, 25);
        chk("R6 halt edge det", det_flag, 8'h08);
        chk("R6 halt edge no req", req_flag, 8'h00);
        chk("R6 halt edge no wake", wake_req, 1'b0);
        clear_all();
    endtask

    task automatic t_stop();
        pwr_mode = 2'd3;
        set_trig(4, 2'd2);
        pulse(4, 10);
        chk("R2 stop level 10-cycle req", req_flag, 8'h10);
        chk("R8 wake in stop", wake_req, 1'b1);
        clear_all();
        pulse(5, 12);
        chk("R6 stop edge det", det_flag, 8'h20);
        chk("R6 stop edge no req", req_flag, 8'h00);
        clear_all();
    endtask

    task automatic t_sleep();
        pwr_mode = 2'd1;
        pulse(6, 10);
        chk("R7 sleep edge req", req_flag, 8'h40);
        chk("R11 only pin6 det", det_flag, 8'h40);
        chk("R7 sleep wake", wake_req, 1'b1);
        clear_all();
        pwr_mode = 2'd0;
    endtask

    task automatic t_set_wins();
        set_trig(7, 2'd2);
        @(negedge clk); pin_in[7] = 1'b1;
        repeat (20) @(negedge clk);
        clr_req = 8'h80;
        @(negedge clk); clr_req = 8'h00;
        @(negedge clk);
        chk("R10 set beats clear", req_flag, 8'h80);
        set_trig(7, 2'd3);
        clear_all();
        chk("R4 low trig idle while high", req_flag, 8'h00);
        pin_in[7] = 1'b0;
        repeat (20) @(negedge clk);
        chk("R4 low level detected", det_flag, 8'h80);
        set_trig(7, 2'd0);
        clear_all();
    endtask

    initial begin
        n_chk    = 0;
        n_bad    = 0;
        rst_n    = 1'b0;
        pin_in   = 8'h00;
        trig_cfg = 16'h0000;
        pwr_mode = 2'd0;
        clr_req  = 8'h00;
        clr_det  = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_norm_window();
        t_falling();
        t_halt_window();
        t_halt_edge();
        t_stop();
        t_sleep();
        t_set_wins();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule